// File: doc/BRIEF.md
# Reloadable Bit-Serial Four-Tap Dot-Product Engine

This block forms the signed dot product of four input samples with four coefficients without a single hardware multiplier. It holds a 16-entry table of partial sums, one entry for each on/off combination of the four coefficients. Each cycle it reads one bit from every sample, least significant bit first, and uses those four bits as the table address. A shift-accumulator weights every table word by the bit position it belongs to. On the sign-bit cycle it subtracts the word instead of adding it, so two's-complement samples come out right.

The table is a chain of shift-register cells with a 16-way tap selector. When nothing is being shifted in, the chain is a plain lookup table. A run-time load request hands four new coefficients to an internal loader. The loader computes the sums and shifts them into the chain over 16 cycles. No rebuild of the design is needed.

Samples enter on a valid/ready stream and results leave on a valid/ready stream. The engine takes one sample set at a time. `s_ready` is low while the engine is busy, while an undelivered result is pending, and in any cycle with a load request. A result stays on `m_result` with `m_valid` high until `m_ready` takes it. Coefficient loading is a plain strobe with a busy flag.

Top module: `da_fir4`

## Requirements
- R1: After reset, `busy` and `m_valid` are 0, `s_ready` is 1, and every table entry is zero, so a sample set processed before any load yields 0.
- R2: The result equals the sum over k of x_k * c_k as signed 19-bit values. Sample k sits in `s_data[8k+7:8k]` and coefficient k in `load_coefs[8k+7:8k]`, both 8-bit two's complement.
- R3: A sample set accepted at a rising edge (`s_valid` and `s_ready` high) raises `busy` for exactly 8 cycles. Its result appears with `m_valid` high right after the 8th following rising edge.
- R4: While `m_valid` is high and `m_ready` is low, `m_result` and `m_valid` hold steady and `s_ready` stays low. `m_valid` drops after the edge where `m_ready` is seen high.
- R5: A load request (`load_en` high while `busy` is low) raises `busy` for exactly 16 cycles. `s_ready` stays low during that time.
- R6: `load_en` asserted while `busy` is high is ignored. The coefficients in use and the busy timing stay unchanged.
- R7: When `load_en` and `s_valid` are both high in an idle cycle, the load wins. `s_ready` is low in that cycle, and the offered sample set is taken later and uses the new coefficients.
- R8: After a load completes, every later result uses the new coefficients. The table keeps them across any number of sample sets, including the extreme values -128 and 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample set offered |
| s_ready | output | 1 | Engine can take a sample set this cycle |
| s_data | input | 32 | Four signed 8-bit samples, sample k at bits 8k+7..8k |
| load_en | input | 1 | Request to load a new coefficient set |
| load_coefs | input | 32 | Four signed 8-bit coefficients, coefficient k at bits 8k+7..8k |
| busy | output | 1 | Loading the table or computing a result |
| m_valid | output | 1 | Result available |
| m_ready | input | 1 | Downstream accepts the result |
| m_result | output | 19 | Signed dot product |

## Verification
The bench aims at the sign-bit cycle. It uses all-minus-128 and mixed 127/-128 operands, where a design that added instead of subtracted would give results off by a large power-of-two multiple. It drives single-hot samples, which show up a table loaded in reversed address order as a swapped coefficient. It fires load requests during a fill and during a computation, where a design that accepted them would corrupt later results or stretch `busy`. It also holds `m_ready` low with a second sample waiting, and offers a load and a sample together, where a design that got the rule wrong would drop or overwrite a result or use stale coefficients.

// File: rtl/da_fir4_pkg.sv
`timescale 1ns/1ps
package da_fir4_pkg;
  typedef enum logic {LD_IDLE = 1'b0, LD_FILL = 1'b1} ld_state_e;
  typedef enum logic {AC_IDLE = 1'b0, AC_RUN = 1'b1} acc_state_e;

  // width of a partial sum of ntaps coefficients of cw bits
  function automatic int sum_width(input int cw, input int ntaps);
    return cw + $clog2(ntaps);
  endfunction
endpackage

// File: rtl/da_coef_loader.sv
`timescale 1ns/1ps
module da_coef_loader
  import da_fir4_pkg::*;
#(
  parameter int NTAPS  = 4,
  parameter int COEF_W = 8,
  parameter int SUM_W  = sum_width(COEF_W, NTAPS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [NTAPS*COEF_W-1:0] coefs_i,
  output logic                    fill_o,
  output logic [SUM_W-1:0]        entry_o
);
  localparam int EXT_W = SUM_W - COEF_W;

  ld_state_e         st;
  logic [NTAPS-1:0]  idx;
  logic [COEF_W-1:0] c_q [NTAPS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= LD_IDLE;
      idx <= '0;
      for (int k = 0; k < NTAPS; k++) c_q[k] <= '0;
    end else begin
      case (st)
        LD_IDLE: if (start_i) begin
          for (int k = 0; k < NTAPS; k++) c_q[k] <= coefs_i[k*COEF_W +: COEF_W];
          idx <= '1;
          st  <= LD_FILL;
        end
        LD_FILL: begin
          idx <= idx - 1'b1;
          if (idx == '0) st <= LD_IDLE;
        end
        default: st <= LD_IDLE;
      endcase
    end
  end

  // entry for address idx: sum of coefficients whose address bit is set
  always_comb begin
    entry_o = '0;
    for (int k = 0; k < NTAPS; k++) begin
      if (idx[k]) entry_o = entry_o + {{EXT_W{c_q[k][COEF_W-1]}}, c_q[k]};
    end
  end

  assign fill_o = (st == LD_FILL);
endmodule

// File: rtl/da_srl_table.sv
`timescale 1ns/1ps
module da_srl_table #(
  parameter int NTAPS = 4,
  parameter int SUM_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_i,
  input  logic [SUM_W-1:0] din_i,
  input  logic [NTAPS-1:0] addr_i,
  output logic [SUM_W-1:0] dout_o
);
  localparam int DEPTH = 1 << NTAPS;

  logic [DEPTH*SUM_W-1:0] flat;

  // cell 0 takes new data; cell g takes cell g-1 on each shift
  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic [SUM_W-1:0] q;
    logic [SUM_W-1:0] nxt;
    if (g == 0) begin : g_head
      assign nxt = din_i;
    end else begin : g_body
      assign nxt = g_cell[g-1].q;
    end
    always_ff @(posedge clk) begin
      if (!rst_n)       q <= '0;
      else if (shift_i) q <= nxt;
    end
    assign flat[g*SUM_W +: SUM_W] = q;
  end

  assign dout_o = flat[addr_i*SUM_W +: SUM_W];
endmodule

// File: rtl/da_serial_acc.sv
`timescale 1ns/1ps
module da_serial_acc
  import da_fir4_pkg::*;
#(
  parameter int NTAPS  = 4,
  parameter int DATA_W = 8,
  parameter int SUM_W  = 10,
  parameter int RES_W  = 19
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic [NTAPS*DATA_W-1:0]   samples_i,
  input  logic [SUM_W-1:0]          tab_i,
  output logic [NTAPS-1:0]          addr_o,
  output logic                      run_o,
  output logic                      done_o,
  output logic signed [RES_W-1:0]   sum_o
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int EXT_W = RES_W - SUM_W;

  acc_state_e               st;
  logic [CNT_W-1:0]         cnt;
  logic signed [RES_W-1:0]  acc;
  logic [DATA_W-1:0]        xs [NTAPS];
  logic signed [RES_W-1:0]  tab_x;
  logic signed [RES_W-1:0]  term;
  logic                     last;

  for (genvar k = 0; k < NTAPS; k++) begin : g_addr
    assign addr_o[k] = xs[k][0];
  end

  assign tab_x = {{EXT_W{tab_i[SUM_W-1]}}, tab_i};
  assign term  = tab_x <<< cnt;
  assign last  = (cnt == CNT_W'(DATA_W - 1));
  assign sum_o = last ? (acc - term) : (acc + term);
  assign run_o = (st == AC_RUN);
  assign done_o = run_o && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= AC_IDLE;
      cnt <= '0;
      acc <= '0;
      for (int k = 0; k < NTAPS; k++) xs[k] <= '0;
    end else begin
      case (st)
        AC_IDLE: if (start_i) begin
          for (int k = 0; k < NTAPS; k++) xs[k] <= samples_i[k*DATA_W +: DATA_W];
          cnt <= '0;
          acc <= '0;
          st  <= AC_RUN;
        end
        AC_RUN: begin
          acc <= sum_o;
          cnt <= cnt + 1'b1;
          for (int k = 0; k < NTAPS; k++) xs[k] <= xs[k] >> 1;
          if (last) st <= AC_IDLE;
        end
        default: st <= AC_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/da_fir4.sv
`timescale 1ns/1ps
module da_fir4
  import da_fir4_pkg::*;
#(
  parameter int NTAPS  = 4,
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  localparam int SUM_W = sum_width(COEF_W, NTAPS),
  localparam int RES_W = SUM_W + DATA_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s_valid,
  output logic                    s_ready,
  input  logic [NTAPS*DATA_W-1:0] s_data,
  input  logic                    load_en,
  input  logic [NTAPS*COEF_W-1:0] load_coefs,
  output logic                    busy,
  output logic                    m_valid,
  input  logic                    m_ready,
  output logic [RES_W-1:0]        m_result
);
  logic                    fill;
  logic [SUM_W-1:0]        entry;
  logic [NTAPS-1:0]        addr;
  logic [SUM_W-1:0]        tab;
  logic                    run;
  logic                    done;
  logic signed [RES_W-1:0] sum;
  logic                    ld_start;
  logic                    s_take;

  assign busy     = fill || run;
  assign ld_start = load_en && !busy;
  assign s_ready  = !busy && !m_valid && !load_en;
  assign s_take   = s_valid && s_ready;

  da_coef_loader #(.NTAPS(NTAPS), .COEF_W(COEF_W), .SUM_W(SUM_W)) u_loader (
    .clk(clk), .rst_n(rst_n), .start_i(ld_start), .coefs_i(load_coefs),
    .fill_o(fill), .entry_o(entry)
  );

  da_srl_table #(.NTAPS(NTAPS), .SUM_W(SUM_W)) u_table (
    .clk(clk), .rst_n(rst_n), .shift_i(fill), .din_i(entry),
    .addr_i(addr), .dout_o(tab)
  );

  da_serial_acc #(.NTAPS(NTAPS), .DATA_W(DATA_W), .SUM_W(SUM_W), .RES_W(RES_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .start_i(s_take), .samples_i(s_data),
    .tab_i(tab), .addr_o(addr), .run_o(run), .done_o(done), .sum_o(sum)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid  <= 1'b0;
      m_result <= '0;
    end else if (done) begin
      m_valid  <= 1'b1;
      m_result <= sum;
    end else if (m_ready) begin
      m_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/da_fir4_checker.sv
`timescale 1ns/1ps
module da_fir4_checker #(
  parameter int NTAPS  = 4,
  parameter int DATA_W = 8,
  parameter int RES_W  = 19
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_valid,
  input logic             s_ready,
  input logic             load_en,
  input logic             busy,
  input logic             m_valid,
  input logic             m_ready,
  input logic [RES_W-1:0] m_result
);
  localparam int DEPTH = 1 << NTAPS;
  localparam int LEN_W = $clog2(DEPTH + DATA_W) + 1;

  logic [LEN_W-1:0] run_len;
  logic             was_load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_len  <= '0;
      was_load <= 1'b0;
    end else begin
      run_len <= busy ? run_len + 1'b1 : '0;
      if (load_en && !busy)        was_load <= 1'b1;
      else if (s_valid && s_ready) was_load <= 1'b0;
    end
  end

  assert_load_starts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_en && !busy |=> busy);

  assert_accept_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready |=> busy && !m_valid);

  assert_result_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_result));

  assert_busy_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == (was_load ? LEN_W'(DEPTH) : LEN_W'(DATA_W))));

  assert_result_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> $fell(busy));
endmodule

bind da_fir4 da_fir4_checker #(.NTAPS(NTAPS), .DATA_W(DATA_W), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .load_en(load_en), .busy(busy), .m_valid(m_valid), .m_ready(m_ready),
  .m_result(m_result)
);

// File: tb/da_fir4_bench.sv
`timescale 1ns/1ps
module da_fir4_bench;
  localparam int NT = 4, DW = 8, CW = 8, RW = 19;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             s_valid = 1'b0;
  logic [NT*DW-1:0] s_data = '0;
  logic             load_en = 1'b0;
  logic [NT*CW-1:0] load_coefs = '0;
  logic             m_ready = 1'b1;
  logic             s_ready, busy, m_valid;
  logic [RW-1:0]    m_result;

  always #10 clk = ~clk;

  da_fir4 u_da_fir4 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .load_en(load_en), .load_coefs(load_coefs),
    .busy(busy), .m_valid(m_valid), .m_ready(m_ready), .m_result(m_result)
  );

  int    n_chk = 0, n_fail = 0;
  bit    finished = 0;
  string tag = "R2";

  int coef_m [NT];
  int ld_left = 0, cmp_left = 0;
  bit exp_mv = 0;
  int q[$];

  task automatic chk(input bit ok, input string t, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic int dot(input logic [NT*DW-1:0] d);
    int s = 0;
    for (int k = 0; k < NT; k++) s += int'($signed(d[k*DW +: DW])) * coef_m[k];
    return s;
  endfunction

  function automatic logic [NT*DW-1:0] pack4(input int a, input int b, input int c, input int d);
    return {DW'(d), DW'(c), DW'(b), DW'(a)};
  endfunction

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      ld_left = 0; cmp_left = 0; exp_mv = 0; q.delete();
      for (int k = 0; k < NT; k++) coef_m[k] = 0;
    end else begin
      bit busy_now, mv_now, take_ld, take_s;
      busy_now = (ld_left > 0) || (cmp_left > 0);
      mv_now   = exp_mv;
      take_ld  = load_en && !busy_now;
      take_s   = s_valid && !busy_now && !mv_now && !load_en;
      if (mv_now && m_ready) begin
        exp_mv = 0;
        if (q.size() > 0) void'(q.pop_front());
      end
      if (ld_left > 0) ld_left--;
      else if (cmp_left > 0) begin
        cmp_left--;
        if (cmp_left == 0) exp_mv = 1;
      end
      if (take_ld) begin
        ld_left = 16;
        for (int k = 0; k < NT; k++) coef_m[k] = int'($signed(load_coefs[k*CW +: CW]));
      end
      if (take_s) begin
        q.push_back(dot(s_data));
        cmp_left = 8;
      end
    end
  end

  // compare against the reference away from the clock edge
  always @(negedge clk) begin
    #2;
    if (rst_n && !finished) begin
      bit eb, er;
      eb = (ld_left > 0) || (cmp_left > 0);
      er = !eb && !exp_mv && !load_en;
      chk(busy == eb, "R5 busy", int'(busy), int'(eb));
      chk(s_ready == er, "R4 s_ready", int'(s_ready), int'(er));
      chk(m_valid == exp_mv, "R3 m_valid", int'(m_valid), int'(exp_mv));
      if (exp_mv && m_valid) begin
        if (q.size() == 0) chk(0, {tag, " result queue"}, 0, 1);
        else chk(int'($signed(m_result)) == q[0], {tag, " result"},
                 int'($signed(m_result)), q[0]);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  task automatic send(input logic [NT*DW-1:0] d);
    @(negedge clk);
    s_valid = 1'b1; s_data = d;
    #1;
    while (!s_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk); #1;
    while (busy) begin @(negedge clk); #1; end
  endtask

  task automatic load(input logic [NT*CW-1:0] c);
    wait_idle();
    @(negedge clk);
    load_en = 1'b1; load_coefs = c;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk); #1;
    while (busy || m_valid || q.size() > 0) begin @(negedge clk); #1; end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #3;
    chk(busy == 0, "R1 busy after reset", int'(busy), 0);
    chk(m_valid == 0, "R1 m_valid after reset", int'(m_valid), 0);
    chk(s_ready == 1, "R1 s_ready after reset", int'(s_ready), 1);

    tag = "R1";
    send(pack4(5, -7, 100, -128));
    drain();

    tag = "R2";
    load(pack4(3, -5, 7, -128));
    // second request during the fill must be ignored (R6)
    @(negedge clk); load_en = 1'b1; load_coefs = pack4(1, 1, 1, 1);
    @(negedge clk); load_en = 1'b0;
    send(pack4(1, 0, 0, 0));
    send(pack4(0, 1, 0, 0));
    send(pack4(0, 0, 1, 0));
    send(pack4(0, 0, 0, 1));
    send(pack4(-1, -1, -1, -1));
    send(pack4(127, -128, 127, -128));
    send(pack4(-128, -128, -128, -128));
    drain();

    tag = "R6";
    send(pack4(10, 20, -30, 40));
    load_en = 1'b1; load_coefs = pack4(9, 9, 9, 9);
    @(negedge clk); load_en = 1'b0;
    send(pack4(2, 2, 2, 2));
    drain();

    tag = "R4";
    m_ready = 1'b0;
    send(pack4(11, -12, 13, -14));
    @(negedge clk);
    s_valid = 1'b1; s_data = pack4(-3, 4, -5, 6);
    repeat (12) @(negedge clk);
    m_ready = 1'b1;
    #1;
    while (!s_ready) begin @(negedge clk); #1; end
    @(negedge clk); s_valid = 1'b0;
    drain();

    tag = "R8";
    load(pack4(-128, -128, -128, -128));
    send(pack4(-128, -128, -128, -128));
    send(pack4(127, 127, 127, 127));
    send(pack4(1, -1, 0, 0));
    drain();

    tag = "R7";
    wait_idle();
    @(negedge clk);
    s_valid = 1'b1; s_data = pack4(1, 2, 3, 4);
    load_en = 1'b1; load_coefs = pack4(2, -3, 4, -5);
    #1;
    chk(s_ready == 0, "R7 load wins over sample", int'(s_ready), 0);
    @(negedge clk); load_en = 1'b0;
    #1;
    while (!s_ready) begin @(negedge clk); #1; end
    @(negedge clk); s_valid = 1'b0;
    drain();

    tag = "R2";
    load(pack4(-77, 45, 127, -1));
    for (int i = 0; i < 24; i++) send(NT*DW'($urandom()));
    drain();

    finish_run();
  end
endmodule